// File: doc/BRIEF.md
# Dual-Channel Prescaled Down-Counting Timer

This block holds a set of identical countdown timer channels (two by default) behind a simple synchronous register bus, plus one shared interrupt flag register. Each channel has a control register, an initial-count register and a read-only count register. Software programs an initial count, a prescale value and a run mode, then sets the enable bit. The channel's counter then steps down once every prescale-plus-one clock cycles.

When the count runs out, the channel raises its flag. In periodic mode the channel reloads the initial count and keeps running, which gives a regular tick. In one-shot mode it stops at zero and clears its own enable bit, which gives a single programmed delay. Software can also read the inverted count of a free-running periodic channel as an up-counting timebase. Each channel drives its own interrupt line, gated by that channel's interrupt enable.

The bus is combinational on reads and takes effect at the clock edge on writes. The word address is split into a block index (upper bits) and a register offset (low two bits).

Top module: `dual_tick_timer`

## Requirements
- R1: After a synchronous reset every register reads zero and every interrupt line is low.
- R2: An enabled channel's counter changes by one step once every P+1 clock cycles, where P is control bits 7:0. A step taken when the counter holds 0 or 1 is an expiry; any other step decrements. The count register returns the counter zero-extended to 32 bits.
- R3: With control bits 28:27 equal to 01 (periodic), an expiry reloads the counter from the low 24 bits of the initial count, and the channel stays enabled.
- R4: With control bits 28:27 set to any value other than 01 (one-shot), an expiry leaves the counter at zero and clears the enable bit (bit 30), and counting stops.
- R5: A control write that takes bit 30 from 0 to 1, or a write to the initial-count register while enabled, loads the counter with the low 24 bits of the initial count and restarts the prescaler from zero. A bus write to a channel takes priority over that channel's count step in the same cycle.
- R6: A control write with bit 30 clear stops the channel, and the counter then holds its value.
- R7: An expiry sets the channel's flag whatever the interrupt enable is. Interrupt line i equals flag i ANDed with control bit 29 of channel i.
- R8: The status register holds flag i in bit i. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R9: For channel i, word address 4*i+0 is control, 4*i+1 is initial count and 4*i+2 is count. Address 8 is status. Control reads return the enable (30), interrupt enable (29), mode (28:27) and prescale (7:0) fields, including an enable bit cleared by hardware, and zeros elsewhere.
- R10: Writes to a count register, and to unmapped addresses, have no effect. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Word address: block index in the upper bits, register offset in bits 1:0 |
| bus_we | input | 1 | Write strobe, acted on at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | NUM_CH (2) | Per-channel interrupt lines |

## Verification
A prescaler phase that is wrong by one slot shows up as a count register reading that is off from the cycle-accurate model. It appears within P+1 cycles of enabling, long before any flag moves. A wrong reload value or a missed stop in one-shot mode shows on the next expiry, either as a count that differs from the initial value or as bit 30 still set in the control readback. Flag corruption shows on irq in the same cycle, because the line is a plain gate of the flag. The bench compares the addressed register and both interrupt lines against its model after every clock, so any of these faults is seen on the first cycle it becomes visible at the ports.

// File: rtl/dtt_pkg.sv
`timescale 1ns/1ps
package dtt_pkg;

    localparam int REG_W    = 32;
    localparam int PRE_W    = 8;
    localparam int EN_BIT   = 30;
    localparam int IE_BIT   = 29;
    localparam int MODE_LSB = 27;

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'b00,
        MODE_REPEAT = 2'b01,
        MODE_RSV_A  = 2'b10,
        MODE_RSV_B  = 2'b11
    } run_mode_e;

    typedef struct packed {
        logic             en;
        logic             ie;
        run_mode_e        mode;
        logic [PRE_W-1:0] pre;
    } chan_cfg_t;

    function automatic chan_cfg_t unpack_ctrl(input logic [REG_W-1:0] w);
        chan_cfg_t c;
        c.en   = w[EN_BIT];
        c.ie   = w[IE_BIT];
        c.mode = run_mode_e'(w[MODE_LSB +: 2]);
        c.pre  = w[PRE_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input chan_cfg_t c);
        logic [REG_W-1:0] w;
        w                = '0;
        w[EN_BIT]        = c.en;
        w[IE_BIT]        = c.ie;
        w[MODE_LSB +: 2] = c.mode;
        w[PRE_W-1:0]     = c.pre;
        return w;
    endfunction

    function automatic logic is_periodic(input run_mode_e m);
        return m == MODE_REPEAT;
    endfunction

endpackage

// File: rtl/dtt_channel.sv
`timescale 1ns/1ps
module dtt_channel
    import dtt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic             init_we,
    input  logic [REG_W-1:0] wdata,
    output chan_cfg_t        cfg_o,
    output logic [REG_W-1:0] init_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    chan_cfg_t        cfg_q;
    chan_cfg_t        wr_cfg;
    logic [REG_W-1:0] init_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] psc_q;
    logic             start;
    logic             tick;
    logic             last_step;

    assign wr_cfg    = unpack_ctrl(wdata);
    assign start     = ctrl_we && wr_cfg.en && !cfg_q.en;
    assign tick      = cfg_q.en && !ctrl_we && !init_we && (psc_q >= cfg_q.pre);
    assign last_step = cnt_q <= CNT_W'(1);
    assign expire_o  = tick && last_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            init_q <= '0;
            cnt_q  <= '0;
            psc_q  <= '0;
        end else if (ctrl_we) begin
            cfg_q <= wr_cfg;
            if (start) begin
                cnt_q <= init_q[CNT_W-1:0];
                psc_q <= '0;
            end
        end else if (init_we) begin
            init_q <= wdata;
            if (cfg_q.en) begin
                cnt_q <= wdata[CNT_W-1:0];
                psc_q <= '0;
            end
        end else if (cfg_q.en) begin
            if (tick) begin
                psc_q <= '0;
                if (last_step) begin
                    if (is_periodic(cfg_q.mode)) begin
                        cnt_q <= init_q[CNT_W-1:0];
                    end else begin
                        cnt_q    <= '0;
                        cfg_q.en <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end else begin
                psc_q <= psc_q + PRE_W'(1);
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign init_o = init_q;
    assign cnt_o  = cnt_q;

    // R2: between prescaler slots the counter does not move
    a_r2_gap_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && !ctrl_we && !init_we && psc_q < cfg_q.pre) |=> $stable(cnt_q));

    // R3: periodic expiry reloads and keeps running
    a_r3_repeat_reload: assert property (@(posedge clk) disable iff (rst)
        (expire_o && is_periodic(cfg_q.mode)) |=>
            (cfg_q.en && cnt_q == $past(init_q[CNT_W-1:0])));

    // R4: one-shot expiry halts at zero with enable cleared
    a_r4_once_halts: assert property (@(posedge clk) disable iff (rst)
        (expire_o && !is_periodic(cfg_q.mode)) |=> (!cfg_q.en && cnt_q == '0));

    // R5: a fresh start loads the initial count and restarts the prescaler
    a_r5_start_load: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == $past(init_q[CNT_W-1:0]) && psc_q == '0));

    // R6: a stopped channel holds its count
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && !ctrl_we) |=> $stable(cnt_q));

endmodule

// File: rtl/dtt_status.sv
`timescale 1ns/1ps
module dtt_status #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] expire,
    input  logic [NUM_CH-1:0] ie,
    output logic [NUM_CH-1:0] flags_o,
    output logic [NUM_CH-1:0] irq_o
);

    logic [NUM_CH-1:0] flags_q;
    logic [NUM_CH-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | expire;
        end
    end

    assign flags_o = flags_q;
    assign irq_o   = flags_q & ie;

    // R7: no interrupt line without its flag
    a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
        (irq_o & ~flags_q) == '0);

    // R8: expiry always lands, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (expire != '0) |=> (($past(expire) & ~flags_q) == '0));

    // R8: flags only fall through a status write
    a_r8_no_spurious_clear: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> (($past(flags_q) & ~flags_q) == '0));

endmodule

// File: rtl/dual_tick_timer.sv
`timescale 1ns/1ps
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int BLK_W    = ADDR_W - 2;
    localparam int STAT_IDX = NUM_CH;
    localparam logic [1:0] OFF_CTRL = 2'd0;
    localparam logic [1:0] OFF_INIT = 2'd1;
    localparam logic [1:0] OFF_CNT  = 2'd2;

    logic [BLK_W-1:0] blk;
    logic [1:0]       off;

    chan_cfg_t         cfg_a  [NUM_CH];
    logic [REG_W-1:0]  init_a [NUM_CH];
    logic [CNT_W-1:0]  cnt_a  [NUM_CH];
    logic [NUM_CH-1:0] expire_v;
    logic [NUM_CH-1:0] ie_v;
    logic [NUM_CH-1:0] flags;
    logic              stat_we;

    assign blk = bus_addr[ADDR_W-1:2];
    assign off = bus_addr[1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ctrl_we_i;
        logic init_we_i;

        assign ctrl_we_i = bus_we && blk == BLK_W'(i) && off == OFF_CTRL;
        assign init_we_i = bus_we && blk == BLK_W'(i) && off == OFF_INIT;

        dtt_channel #(.CNT_W(CNT_W)) chan_i (
            .clk      (clk),
            .rst      (rst),
            .ctrl_we  (ctrl_we_i),
            .init_we  (init_we_i),
            .wdata    (bus_wdata),
            .cfg_o    (cfg_a[i]),
            .init_o   (init_a[i]),
            .cnt_o    (cnt_a[i]),
            .expire_o (expire_v[i])
        );

        assign ie_v[i] = cfg_a[i].ie;
    end

    assign stat_we = bus_we && blk == BLK_W'(STAT_IDX) && off == OFF_CTRL;

    dtt_status #(.NUM_CH(NUM_CH)) status_i (
        .clk      (clk),
        .rst      (rst),
        .clr_we   (stat_we),
        .clr_bits (bus_wdata[NUM_CH-1:0]),
        .expire   (expire_v),
        .ie       (ie_v),
        .flags_o  (flags),
        .irq_o    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (blk == BLK_W'(i)) begin
                case (off)
                    OFF_CTRL: bus_rdata = pack_ctrl(cfg_a[i]);
                    OFF_INIT: bus_rdata = init_a[i];
                    OFF_CNT:  bus_rdata = REG_W'(cnt_a[i]);
                    default:  bus_rdata = '0;
                endcase
            end
        end
        if (blk == BLK_W'(STAT_IDX) && off == OFF_CTRL) begin
            bus_rdata = REG_W'(flags);
        end
    end

endmodule

// File: tb/dual_tick_timer_tb.sv
`timescale 1ns/1ps
module dual_tick_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_tick_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    // behavioural reference state
    bit          m_en   [2];
    bit          m_ie   [2];
    logic [1:0]  m_mode [2];
    logic [7:0]  m_pre  [2];
    logic [31:0] m_init [2];
    logic [23:0] m_cnt  [2];
    int          m_psc  [2];
    logic [1:0]  m_flag;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_en[c] = 0; m_ie[c] = 0; m_mode[c] = 0; m_pre[c] = 0;
                m_init[c] = 0; m_cnt[c] = 0; m_psc[c] = 0;
            end
            m_flag = 0;
        end else begin
            logic [1:0] hit;
            hit = 0;
            for (int c = 0; c < 2; c++) begin
                bit wc, wi;
                wc = we && addr[3:2] == c && addr[1:0] == 0;
                wi = we && addr[3:2] == c && addr[1:0] == 1;
                if (wc) begin
                    if (wdata[30] && !m_en[c]) begin
                        m_cnt[c] = m_init[c][23:0];
                        m_psc[c] = 0;
                    end
                    m_en[c] = wdata[30]; m_ie[c] = wdata[29];
                    m_mode[c] = wdata[28:27]; m_pre[c] = wdata[7:0];
                end else if (wi) begin
                    m_init[c] = wdata;
                    if (m_en[c]) begin
                        m_cnt[c] = wdata[23:0];
                        m_psc[c] = 0;
                    end
                end else if (m_en[c]) begin
                    if (m_psc[c] >= int'(m_pre[c])) begin
                        m_psc[c] = 0;
                        if (m_cnt[c] <= 1) begin
                            hit[c] = 1;
                            if (m_mode[c] == 2'b01) m_cnt[c] = m_init[c][23:0];
                            else begin m_cnt[c] = 0; m_en[c] = 0; end
                        end else m_cnt[c] = m_cnt[c] - 1;
                    end else m_psc[c] = m_psc[c] + 1;
                end
            end
            if (we && addr == 4'd8) m_flag = m_flag & ~wdata[1:0];
            m_flag = m_flag | hit;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        int b;
        b = int'(a[3:2]);
        if (b < 2) begin
            case (a[1:0])
                2'd0: return {1'b0, m_en[b], m_ie[b], m_mode[b], 19'b0, m_pre[b]};
                2'd1: return m_init[b];
                2'd2: return {8'b0, m_cnt[b]};
                default: return 32'h0;
            endcase
        end
        if (a == 4'd8) return {30'b0, m_flag};
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always begin
        @(posedge clk);
        #2;
        if (!rst && !done) begin
            string tag;
            if (addr == 4'd8) tag = "R8 status";
            else if (addr[1:0] == 2'd2) tag = "R2 count";
            else if (addr[3:2] == 2'd3 || addr[1:0] == 2'd3) tag = "R10 unmapped";
            else tag = "R9 register";
            chk(tag, rdata, m_read(addr));
            chk("R7 irq", {30'b0, irq}, {30'b0, m_flag & {m_ie[1], m_ie[0]}});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        @(posedge clk);
        #2;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        foreach (v2[k]) begin end
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 reset irq", {30'b0, irq}, 32'h0);

        // R9: control readback drops unused bits
        wr(4'd4, 32'h2800_1F03);
        rd(4'd4, v);
        chk("R9 ctrl fields", v, 32'h2800_0003);
        wr(4'd4, 32'h0);

        // R5 / R3: periodic channel 0, prescale 2
        wr(4'd1, 32'hFF00_0005);
        rd(4'd1, v);
        chk("R9 init readback", v, 32'hFF00_0005);
        wr(4'd0, 32'h6800_0002);
        rd(4'd2, v);
        chk("R5 start load", v, 32'h0000_0005);
        idle(40);
        rd(4'd0, v);
        chk("R3 still enabled", {31'b0, v[30]}, 32'h1);
        rd(4'd8, v);
        chk("R7 flag0 set", {31'b0, v[0]}, 32'h1);

        // R8: writing zero keeps, writing one clears
        wr(4'd0, 32'h2800_0002);
        wr(4'd8, 32'h0);
        rd(4'd8, v);
        chk("R8 zero write keeps", {31'b0, v[0]}, 32'h1);
        wr(4'd8, 32'h1);
        rd(4'd8, v);
        chk("R8 one write clears", {31'b0, v[0]}, 32'h0);

        // R6: stopped channel holds its count
        wr(4'd0, 32'h0);
        rd(4'd2, v);
        idle(7);
        rd(4'd2, v2);
        chk("R6 count holds", v2, v);
        chk("R6 irq low", {31'b0, irq[0]}, 32'h0);

        // R4 / R7: one-shot channel 1, interrupts masked
        wr(4'd5, 32'h0000_0003);
        wr(4'd4, 32'h4000_0000);
        idle(10);
        rd(4'd4, v);
        chk("R4 enable cleared", {31'b0, v[30]}, 32'h0);
        rd(4'd6, v);
        chk("R4 count zero", v, 32'h0);
        rd(4'd8, v);
        chk("R7 flag1 without ie", {31'b0, v[1]}, 32'h1);
        chk("R7 irq1 masked", {31'b0, irq[1]}, 32'h0);
        wr(4'd4, 32'h2000_0000);
        idle(1);
        chk("R7 irq1 follows ie", {31'b0, irq[1]}, 32'h1);

        // R10: count register and unmapped writes ignored
        wr(4'd6, 32'h00AB_CDEF);
        rd(4'd6, v);
        chk("R10 count write ignored", v, 32'h0);
        wr(4'd15, 32'hFFFF_FFFF);
        rd(4'd5, v);
        chk("R10 unmapped write ignored", v, 32'h3);

        // R4: reserved mode value behaves as one-shot
        wr(4'd5, 32'h0000_0002);
        wr(4'd4, 32'h5000_0000);
        idle(8);
        rd(4'd4, v);
        chk("R4 mode 10 one-shot", {31'b0, v[30]}, 32'h0);

        // R5: init write while running restarts from new value
        wr(4'd1, 32'h0000_0020);
        wr(4'd0, 32'h4800_0004);
        idle(12);
        wr(4'd1, 32'h0000_0030);
        rd(4'd2, v);
        chk("R5 reload on init write", v, 32'h30);

        // R2: prescale 3 with a long count, sampled by the model each cycle
        wr(4'd5, 32'h0000_0064);
        wr(4'd4, 32'h4800_0003);
        addr = 4'd6;
        idle(30);

        // R8: expiry every cycle beats a simultaneous clear
        wr(4'd1, 32'h0000_0001);
        wr(4'd0, 32'h4800_0000);
        idle(3);
        wr(4'd8, 32'h1);
        wr(4'd8, 32'h1);
        rd(4'd8, v);
        chk("R8 set beats clear", {31'b0, v[0]}, 32'h1);

        // R8: all ones clears both after stopping
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0);
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, v);
        chk("R8 clear all", v, 32'h0);

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule